// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides the power state of a small microcontroller-style system and drives the enables that carry out that state. The enables are the core clock, the peripheral clock, two high-frequency oscillators, the regulator bias mode, the internal low-voltage regulator, pin-state retention, and a low-frequency clock that keeps the wake timers running. Software asks for a state by writing a request register. Two more registers set the stop flavour and the oscillator settle time.

There are six power states. From normal, software can enter idle, suspend, snooze, stop or shutdown. Each state has its own entry precondition and its own set of exit sources:

- Idle ends on an interrupt.
- Suspend and snooze end on a set of peripheral wake events. On wake, the oscillators come back first. The clocks return only after a programmable settle count.
- Stop ends on any reset source.
- Shutdown ends only on a pin reset or a power-on reset.

An active-low asynchronous reset models the power-on reset. It returns every register to its default.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After power-on reset, the mode output is normal (code 0). In normal mode the core clock, peripheral clock, both oscillators and the low-voltage regulator are enabled. Low bias, pin hold, the low-frequency timer clock and the error flag are all 0.
- R2: In normal mode, a write of bit 0 at address 0 enters idle (code 1) on the next cycle. Idle stops only the core clock. An interrupt input returns the block to normal on the following cycle.
- R3: A suspend request (address 0 bit 1) or a snooze request (address 0 bit 2) is accepted only while sysclk_hf0_i is 1. Otherwise the mode stays normal and the error flag sets. The error flag holds until an accepted reset source (pin or system) clears it.
- R4: Suspend (code 2) and snooze (code 3) both disable both clocks and both oscillators, and both enable the low-frequency timer clock. Suspend keeps normal bias; snooze selects low bias.
- R5: Suspend and snooze leave for the settle state on any one of: USB activity, low-frequency timer event, SPI activity, I2C slave activity, port match, or comparator falling edge. The interrupt input alone does not wake them.
- R6: On wake from suspend or snooze, the block enters settle (code 6) with both oscillators on and both clocks off. Normal mode, with clocks enabled, follows exactly N+1 cycles after the wake edge, where N is the value written at address 2 (reset value 4).
- R7: With address 1 bit 0 clear, a write of address 0 bit 3 enters stop (code 4). Stop keeps the low-voltage regulator on, sets pin hold, and turns off clocks and oscillators. Wake inputs and interrupts have no effect. A pin reset or a system reset returns the block to normal on the next cycle.
- R8: With address 1 bit 0 set, the stop request enters shutdown (code 5). Shutdown turns the low-voltage regulator off and sets pin hold. It ignores system reset, wake inputs and interrupts; only pin reset returns it to normal. A pin or system reset also clears address 1 bit 0 and restores address 2 to its reset value.
- R9: When one write at address 0 sets several request bits, stop wins over suspend, suspend over snooze, and snooze over idle. A rejected suspend or snooze does not fall through to idle.
- R10: The comparator wakes suspend or snooze only on a high-to-low transition. A level held low, or a rising edge, leaves the mode unchanged.
- R11: Request writes made outside normal mode are ignored.
- R12: mode_o takes only the codes 0 to 6 listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 request, 1 stop flavour, 2 settle count) |
| wr_data_i | input | 8 | Register write data |
| sysclk_hf0_i | input | 1 | System clock is taken from oscillator 0 |
| irq_i | input | 1 | Any pending interrupt |
| pin_rst_i | input | 1 | Pin reset, synchronous |
| sys_rst_i | input | 1 | Any other reset source, synchronous |
| usb_act_i | input | 1 | USB bus activity |
| lf_tmr_evt_i | input | 1 | Low-frequency timer event |
| spi_act_i | input | 1 | SPI activity |
| i2c_act_i | input | 1 | I2C slave activity |
| port_match_i | input | 1 | Port match event |
| cmp_i | input | 1 | Comparator output level |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| hfosc0_en_o | output | 1 | Oscillator 0 enable |
| hfosc1_en_o | output | 1 | Oscillator 1 enable |
| reg_low_bias_o | output | 1 | Regulator low-bias select |
| ldo_en_o | output | 1 | Low-voltage regulator enable |
| pin_hold_o | output | 1 | Hold pin states |
| lf_tmr_clk_en_o | output | 1 | Low-frequency clock to wake timers |
| mode_o | output | 3 | Current power state code |
| err_o | output | 1 | Sticky rejected-request flag |

## Verification
The request register is swept over all sixteen bit patterns, each with the oscillator-0 precondition both true and false. This separates the priority order from the precondition rejection and from error-flag setting.

Each of the six wake sources is then applied alone, in suspend and in snooze, at three settle counts. This tells a missing source apart from a wrong wake set and from an off-by-one settle delay.

Separate sequences apply every exit stimulus in stop and in shutdown, plus interrupt, pin and system reset. These show which source leaves each state. A comparator sequence with a held-low level and a rising edge confirms that only the falling edge wakes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_IDLE   = 3'd1,
    PM_SUSP   = 3'd2,
    PM_SNOOZE = 3'd3,
    PM_STOP   = 3'd4,
    PM_SHDN   = 3'd5,
    PM_SETTLE = 3'd6
  } pm_state_e;

  typedef struct packed {
    logic core_clk;
    logic periph_clk;
    logic hfosc0;
    logic hfosc1;
    logic low_bias;
    logic ldo;
    logic pin_hold;
    logic lf_tmr;
  } pm_ctl_t;

  localparam int REQ_W      = 4;
  localparam int REQ_IDLE   = 0;
  localparam int REQ_SUSP   = 1;
  localparam int REQ_SNOOZE = 2;
  localparam int REQ_STOP   = 3;

  localparam int ADDR_REQ    = 0;
  localparam int ADDR_CFG    = 1;
  localparam int ADDR_SETTLE = 2;

endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int AW         = 2,
  parameter int DW         = 8,
  parameter int CNT_W      = 8,
  parameter int SETTLE_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_clr_i,
  input  logic             fault_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             req_vld_o,
  output logic [REQ_W-1:0] req_bits_o,
  output logic             stop_cfg_o,
  output logic [CNT_W-1:0] settle_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] SETTLE_DEF = CNT_W'(SETTLE_RST);

  logic wr_req, wr_cfg, wr_set;

  assign wr_req = wr_en_i && (wr_addr_i == AW'(ADDR_REQ));
  assign wr_cfg = wr_en_i && (wr_addr_i == AW'(ADDR_CFG));
  assign wr_set = wr_en_i && (wr_addr_i == AW'(ADDR_SETTLE));

  // request bits are strobes, never stored
  assign req_vld_o  = wr_req;
  assign req_bits_o = wr_data_i[REQ_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_cfg_o <= 1'b0;
      settle_o   <= SETTLE_DEF;
      err_o      <= 1'b0;
    end else if (soft_clr_i) begin
      stop_cfg_o <= 1'b0;
      settle_o   <= SETTLE_DEF;
      err_o      <= 1'b0;
    end else begin
      if (wr_cfg) stop_cfg_o <= wr_data_i[0];
      if (wr_set) settle_o   <= wr_data_i[CNT_W-1:0];
      if (fault_i) err_o     <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake #(
  parameter int N_LVL = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] lvl_src_i,
  input  logic             cmp_i,
  output logic             cmp_fall_o,
  output logic             wake_o
);

  logic cmp_q;
  logic [N_LVL:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= 1'b0;
    else         cmp_q <= cmp_i;
  end

  assign cmp_fall_o = cmp_q && !cmp_i;

  assign hit[0] = cmp_fall_o;
  for (genvar g = 0; g < N_LVL; g++) begin : g_src
    assign hit[g+1] = lvl_src_i[g];
  end

  assign wake_o = |hit;

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic [REQ_W-1:0] req_bits_i,
  input  logic             stop_cfg_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             sysclk_ok_i,
  input  logic             irq_i,
  input  logic             wake_i,
  input  logic             pin_rst_i,
  input  logic             sys_rst_i,
  output pm_state_e        state_o,
  output logic             fault_o,
  output logic             rst_acc_o
);

  pm_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             deep_req;

  // shutdown only listens to the pin
  assign rst_acc_o = pin_rst_i || (sys_rst_i && (state_q != PM_SHDN));

  assign deep_req = !req_bits_i[REQ_STOP] &&
                    (req_bits_i[REQ_SUSP] || req_bits_i[REQ_SNOOZE]);
  assign fault_o  = !rst_acc_o && (state_q == PM_RUN) && req_vld_i &&
                    deep_req && !sysclk_ok_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (rst_acc_o) begin
      state_d = PM_RUN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (req_vld_i) begin
            if (req_bits_i[REQ_STOP])
              state_d = stop_cfg_i ? PM_SHDN : PM_STOP;
            else if (req_bits_i[REQ_SUSP])
              state_d = sysclk_ok_i ? PM_SUSP : PM_RUN;
            else if (req_bits_i[REQ_SNOOZE])
              state_d = sysclk_ok_i ? PM_SNOOZE : PM_RUN;
            else if (req_bits_i[REQ_IDLE])
              state_d = PM_IDLE;
          end
        end
        PM_IDLE: if (irq_i) state_d = PM_RUN;
        PM_SUSP, PM_SNOOZE: begin
          if (wake_i) begin
            state_d = PM_SETTLE;
            cnt_d   = settle_i;
          end
        end
        PM_SETTLE: begin
          if (cnt_q == '0) state_d = PM_RUN;
          else             cnt_d   = cnt_q - 1'b1;
        end
        PM_STOP, PM_SHDN: state_d = state_q;
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pwr_seq_outdec.sv
module pwr_seq_outdec
  import pwr_seq_pkg::*;
(
  input  pm_state_e state_i,
  output pm_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    ctl_o.ldo = 1'b1;
    unique case (state_i)
      PM_RUN: begin
        ctl_o.core_clk   = 1'b1;
        ctl_o.periph_clk = 1'b1;
        ctl_o.hfosc0     = 1'b1;
        ctl_o.hfosc1     = 1'b1;
      end
      PM_IDLE: begin
        ctl_o.periph_clk = 1'b1;
        ctl_o.hfosc0     = 1'b1;
        ctl_o.hfosc1     = 1'b1;
      end
      PM_SUSP:   ctl_o.lf_tmr = 1'b1;
      PM_SNOOZE: begin
        ctl_o.lf_tmr   = 1'b1;
        ctl_o.low_bias = 1'b1;
      end
      PM_STOP: ctl_o.pin_hold = 1'b1;
      PM_SHDN: begin
        ctl_o.pin_hold = 1'b1;
        ctl_o.ldo      = 1'b0;
      end
      PM_SETTLE: begin
        ctl_o.hfosc0 = 1'b1;
        ctl_o.hfosc1 = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int AW         = 2,
  parameter int DW         = 8,
  parameter int CNT_W      = 8,
  parameter int SETTLE_RST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sysclk_hf0_i,
  input  logic          irq_i,
  input  logic          pin_rst_i,
  input  logic          sys_rst_i,
  input  logic          usb_act_i,
  input  logic          lf_tmr_evt_i,
  input  logic          spi_act_i,
  input  logic          i2c_act_i,
  input  logic          port_match_i,
  input  logic          cmp_i,
  output logic          core_clk_en_o,
  output logic          periph_clk_en_o,
  output logic          hfosc0_en_o,
  output logic          hfosc1_en_o,
  output logic          reg_low_bias_o,
  output logic          ldo_en_o,
  output logic          pin_hold_o,
  output logic          lf_tmr_clk_en_o,
  output logic [2:0]    mode_o,
  output logic          err_o
);

  localparam int N_LVL = 5;

  logic             req_vld, stop_cfg, fault, rst_acc, wake, cmp_fall;
  logic [REQ_W-1:0] req_bits;
  logic [CNT_W-1:0] settle;
  logic [N_LVL-1:0] lvl_src;
  pm_state_e        state;
  pm_ctl_t          ctl;

  assign lvl_src = {usb_act_i, lf_tmr_evt_i, spi_act_i, i2c_act_i, port_match_i};

  pwr_seq_regs #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W), .SETTLE_RST(SETTLE_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (rst_acc),
    .fault_i    (fault),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .req_vld_o  (req_vld),
    .req_bits_o (req_bits),
    .stop_cfg_o (stop_cfg),
    .settle_o   (settle),
    .err_o      (err_o)
  );

  pwr_seq_wake #(.N_LVL(N_LVL)) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_src_i  (lvl_src),
    .cmp_i      (cmp_i),
    .cmp_fall_o (cmp_fall),
    .wake_o     (wake)
  );

  pwr_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_vld_i   (req_vld),
    .req_bits_i  (req_bits),
    .stop_cfg_i  (stop_cfg),
    .settle_i    (settle),
    .sysclk_ok_i (sysclk_hf0_i),
    .irq_i       (irq_i),
    .wake_i      (wake),
    .pin_rst_i   (pin_rst_i),
    .sys_rst_i   (sys_rst_i),
    .state_o     (state),
    .fault_o     (fault),
    .rst_acc_o   (rst_acc)
  );

  pwr_seq_outdec u_dec (
    .state_i (state),
    .ctl_o   (ctl)
  );

  assign core_clk_en_o   = ctl.core_clk;
  assign periph_clk_en_o = ctl.periph_clk;
  assign hfosc0_en_o     = ctl.hfosc0;
  assign hfosc1_en_o     = ctl.hfosc1;
  assign reg_low_bias_o  = ctl.low_bias;
  assign ldo_en_o        = ctl.ldo;
  assign pin_hold_o      = ctl.pin_hold;
  assign lf_tmr_clk_en_o = ctl.lf_tmr;
  assign mode_o          = state;

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       sysclk_hf0_i,
  input logic       irq_i,
  input logic       pin_rst_i,
  input logic       sys_rst_i,
  input logic       usb_act_i,
  input logic       lf_tmr_evt_i,
  input logic       spi_act_i,
  input logic       i2c_act_i,
  input logic       port_match_i,
  input logic       cmp_i,
  input logic       core_clk_en_o,
  input logic       periph_clk_en_o,
  input logic       hfosc0_en_o,
  input logic       hfosc1_en_o,
  input logic       reg_low_bias_o,
  input logic       ldo_en_o,
  input logic       pin_hold_o,
  input logic       lf_tmr_clk_en_o,
  input logic [2:0] mode_o,
  input logic       err_o
);

  logic deep, quiet, no_rst;
  assign deep   = (mode_o == 3'd2) || (mode_o == 3'd3);
  assign quiet  = !usb_act_i && !lf_tmr_evt_i && !spi_act_i && !i2c_act_i &&
                  !port_match_i && cmp_i;
  assign no_rst = !pin_rst_i && !sys_rst_i;

  a_r1_run_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd0 |-> core_clk_en_o && periph_clk_en_o && hfosc0_en_o &&
                       hfosc1_en_o && ldo_en_o && !pin_hold_o);

  a_r2_idle_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd1 |-> !core_clk_en_o && periph_clk_en_o);

  a_r2_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && irq_i) |=> mode_o == 3'd0);

  a_r3_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && no_rst && wr_en_i && wr_addr_i == 2'd0 &&
     wr_data_i[3:0] == 4'b0010 && !sysclk_hf0_i) |=> (mode_o == 3'd0 && err_o));

  a_r3_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && no_rst) |=> err_o);

  a_r4_deep_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep |-> !core_clk_en_o && !periph_clk_en_o && !hfosc0_en_o &&
             !hfosc1_en_o && lf_tmr_clk_en_o);

  a_r4_bias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep |-> (reg_low_bias_o == (mode_o == 3'd3)));

  a_r5_no_spurious_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deep && quiet && no_rst) |=> mode_o == $past(mode_o));

  a_r6_settle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd6 |-> hfosc0_en_o && hfosc1_en_o && !core_clk_en_o &&
                       !periph_clk_en_o);

  a_r7_stop_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd4 |-> ldo_en_o && pin_hold_o && !hfosc0_en_o && !core_clk_en_o);

  a_r7_stop_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && !no_rst) |=> mode_o == 3'd0);

  a_r8_shdn_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd5 |-> !ldo_en_o && pin_hold_o);

  a_r8_shdn_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && !pin_rst_i) |=> mode_o == 3'd5);

  a_r12_mode_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 3'd7);

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .sysclk_hf0_i(sysclk_hf0_i), .irq_i(irq_i),
  .pin_rst_i(pin_rst_i), .sys_rst_i(sys_rst_i), .usb_act_i(usb_act_i),
  .lf_tmr_evt_i(lf_tmr_evt_i), .spi_act_i(spi_act_i), .i2c_act_i(i2c_act_i),
  .port_match_i(port_match_i), .cmp_i(cmp_i), .core_clk_en_o(core_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o), .hfosc0_en_o(hfosc0_en_o),
  .hfosc1_en_o(hfosc1_en_o), .reg_low_bias_o(reg_low_bias_o),
  .ldo_en_o(ldo_en_o), .pin_hold_o(pin_hold_o),
  .lf_tmr_clk_en_o(lf_tmr_clk_en_o), .mode_o(mode_o), .err_o(err_o)
);

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       sysclk_hf0_i = 1'b1;
  logic       irq_i = 1'b0, pin_rst_i = 1'b0, sys_rst_i = 1'b0;
  logic       usb_act_i = 1'b0, lf_tmr_evt_i = 1'b0, spi_act_i = 1'b0;
  logic       i2c_act_i = 1'b0, port_match_i = 1'b0, cmp_i = 1'b0;
  logic       core_clk_en_o, periph_clk_en_o, hfosc0_en_o, hfosc1_en_o;
  logic       reg_low_bias_o, ldo_en_o, pin_hold_o, lf_tmr_clk_en_o, err_o;
  logic [2:0] mode_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  pwr_seq_ctrl uut (.*);

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_mode(input int exp, input string req);
    check(mode_o == 3'(exp), req, mode_o, exp);
  endtask

  // expected enable vector {core,periph,hf0,hf1,lowbias,ldo,hold,lftmr} per mode
  function automatic logic [7:0] exp_ctl(input int m);
    case (m)
      0: return 8'b1111_0100;
      1: return 8'b0111_0100;
      2: return 8'b0000_0101;
      3: return 8'b0000_1101;
      4: return 8'b0000_0110;
      5: return 8'b0000_0010;
      default: return 8'b0011_0100;
    endcase
  endfunction

  task automatic chk_ctl(input int m, input string req);
    logic [7:0] a;
    a = {core_clk_en_o, periph_clk_en_o, hfosc0_en_o, hfosc1_en_o,
         reg_low_bias_o, ldo_en_o, pin_hold_o, lf_tmr_clk_en_o};
    check(a == exp_ctl(m), req, a, exp_ctl(m));
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = 2'(a); wr_data_i = 8'(d);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic sys_reset();
    sys_rst_i = 1'b1; step(); sys_rst_i = 1'b0;
  endtask

  task automatic pin_reset();
    pin_rst_i = 1'b1; step(); pin_rst_i = 1'b0;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: usb_act_i = v;
      1: lf_tmr_evt_i = v;
      2: spi_act_i = v;
      3: i2c_act_i = v;
      4: port_match_i = v;
      default: cmp_i = ~v;
    endcase
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int exp_m;
    bit exp_e;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    step();
    // R1 reset state
    chk_mode(0, "R1 mode");
    chk_ctl(0, "R1 outputs");
    check(err_o == 1'b0, "R1 err", err_o, 0);

    // R9 R3 R12 request sweep
    for (int v = 0; v < 16; v++) begin
      for (int ok = 0; ok < 2; ok++) begin
        sysclk_hf0_i = ok[0];
        wr(0, v);
        if (v[3])      exp_m = 4;
        else if (v[1]) exp_m = ok ? 2 : 0;
        else if (v[2]) exp_m = ok ? 3 : 0;
        else if (v[0]) exp_m = 1;
        else           exp_m = 0;
        exp_e = !v[3] && (v[1] || v[2]) && (ok == 0);
        chk_mode(exp_m, "R9 priority");
        chk_ctl(exp_m, "R12 outputs per mode");
        check(err_o == exp_e, "R3 err flag", err_o, exp_e);
        step();
        check(err_o == exp_e, "R3 err sticky", err_o, exp_e);
        sys_reset();
        chk_mode(0, "R7 reset exit");
        check(err_o == 1'b0, "R3 err cleared", err_o, 0);
      end
    end
    sysclk_hf0_i = 1'b1;

    // R2 idle and R11
    wr(0, 1);
    chk_mode(1, "R2 idle entry");
    chk_ctl(1, "R2 idle outputs");
    usb_act_i = 1'b1; step(); usb_act_i = 1'b0;
    chk_mode(1, "R2 idle ignores usb");
    wr(0, 8);
    chk_mode(1, "R11 stop ignored in idle");
    irq_i = 1'b1; step(); irq_i = 1'b0;
    chk_mode(0, "R2 irq wake");

    // R5 R6 wake sweep
    for (int snz = 0; snz < 2; snz++) begin
      for (int s = 0; s < 6; s++) begin
        for (int k = 0; k < 3; k++) begin
          int n;
          n = (k == 0) ? 0 : (k == 1) ? 2 : 5;
          wr(2, n);
          if (s == 5) cmp_i = 1'b1;
          wr(0, snz ? 4 : 2);
          chk_mode(snz ? 3 : 2, "R4 deep entry");
          chk_ctl(snz ? 3 : 2, "R4 deep outputs");
          irq_i = 1'b1; step(); irq_i = 1'b0;
          chk_mode(snz ? 3 : 2, "R5 irq no wake");
          wr(0, 1);
          chk_mode(snz ? 3 : 2, "R11 idle ignored in deep");
          set_src(s, 1'b1); step(); set_src(s, 1'b0);
          chk_mode(6, "R5 wake source");
          chk_ctl(6, "R6 settle outputs");
          for (int j = 0; j < n; j++) begin
            step();
            chk_mode(6, "R6 still settling");
          end
          step();
          chk_mode(0, "R6 settle done");
          check(core_clk_en_o == 1'b1, "R6 core clock back", core_clk_en_o, 1);
          cmp_i = 1'b0;
          step();
        end
      end
    end

    // R10 comparator edges
    cmp_i = 1'b0;
    wr(0, 2);
    step(); step();
    chk_mode(2, "R10 low level no wake");
    cmp_i = 1'b1; step();
    chk_mode(2, "R10 rising no wake");
    cmp_i = 1'b0; step();
    chk_mode(6, "R10 falling wakes");
    sys_reset();
    chk_mode(0, "R7 reset exits settle");

    // R7 stop
    wr(1, 0);
    wr(0, 8);
    chk_mode(4, "R7 stop entry");
    chk_ctl(4, "R7 stop outputs");
    usb_act_i = 1; lf_tmr_evt_i = 1; spi_act_i = 1; i2c_act_i = 1;
    port_match_i = 1; irq_i = 1; cmp_i = 1;
    step();
    usb_act_i = 0; lf_tmr_evt_i = 0; spi_act_i = 0; i2c_act_i = 0;
    port_match_i = 0; irq_i = 0; cmp_i = 0;
    step();
    chk_mode(4, "R7 wake inputs ignored");
    pin_reset();
    chk_mode(0, "R7 pin reset exit");
    wr(0, 8);
    sys_reset();
    chk_mode(0, "R7 sys reset exit");

    // R8 shutdown
    wr(1, 1);
    wr(0, 8);
    chk_mode(5, "R8 shutdown entry");
    chk_ctl(5, "R8 shutdown outputs");
    sys_reset();
    chk_mode(5, "R8 sys reset ignored");
    usb_act_i = 1; irq_i = 1; step(); usb_act_i = 0; irq_i = 0;
    chk_mode(5, "R8 wake ignored");
    pin_reset();
    chk_mode(0, "R8 pin reset exit");
    wr(0, 8);
    chk_mode(4, "R8 flag cleared by reset");
    sys_reset();

    // R6 settle default restored by reset
    wr(2, 1);
    sys_reset();
    wr(0, 2);
    port_match_i = 1; step(); port_match_i = 0;
    for (int j = 0; j < 4; j++) begin
      step();
      chk_mode(6, "R6 default count");
    end
    step();
    chk_mode(0, "R6 default count done");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule